// File: doc/BRIEF.md
# Pulse Tone Channel with Volume Envelope

This block is one pulse-wave voice of a retro-style sound unit. Software programs it through a small write port holding two 16-bit words. The first word carries the duty choice and the envelope setup: starting loudness, direction and step time. The second word carries an 11-bit pitch rate and a restart flag. While the voice is running, every pulse of the period-tick enable moves a pitch counter upwards. Each time that counter rolls over, the voice advances one position through an eight-position duty pattern. The pitch therefore comes out as 2^17 / (2048 − rate) when the period tick runs at 1,048,576 Hz.

A separate 64 Hz enable drives the envelope. The envelope raises or lowers the voice volume by one unit at a time, always in one direction, and stops at the end of the range. The 4-bit output is the current volume while the duty pattern is high and zero while it is low. The output stays at zero until the first restart. Sweep, length timing, mixing, panning and conversion to analogue live outside this block.

Top module: `pulse_tone_voice`

## Requirements
- R1: After reset the output is 0. It stays 0, whatever control writes, plain frequency writes and ticks occur, until the first frequency write with the restart bit set.
- R2: With wr_sel=0 a write stores the control word: bits 15:12 hold the starting volume, bit 11 the direction (1 = rise), bits 10:8 the step time and bits 7:6 the duty code. With wr_sel=1 a write stores the rate from bits 10:0, and bit 15 requests a restart.
- R3: While running, each duty position lasts exactly 2048 − rate period ticks. The position index wraps from 7 back to 0.
- R4: The duty code selects the number of high positions, always counted from position 0: code 0 gives position 0 only, code 1 gives positions 0–1, code 2 gives positions 0–3, code 3 gives positions 0–5. The output equals the volume on a high position and 0 on a low one.
- R5: With direction 0 and step time P>0, the volume drops by 1 after every P envelope ticks. It then holds at 0.
- R6: With direction 1 and step time P>0, the volume rises by 1 after every P envelope ticks. It then holds at 15.
- R7: With step time 0, the volume keeps its starting value regardless of envelope ticks.
- R8: A restart sets the duty position to 0, the counter to the written rate and the volume to the stored starting value, and it restarts the envelope countdown. This holds even in the middle of a note.
- R9: A frequency write without restart leaves the current duty position's length unchanged. The new rate takes effect at the next counter rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | Word select: 0 control, 1 frequency |
| wr_data | input | 16 | Write data |
| period_tick | input | 1 | Pitch-counter enable |
| env_tick | input | 1 | 64 Hz envelope enable |
| sample | output | 4 | Amplitude output |

## Verification
On every cycle the assertions check these properties: the duty position moves only on a period tick and returns to 0 on restart; the volume never moves against the latched direction and changes by at most one unit per cycle; a zero step time freezes the volume; the output is always either 0 or the current volume, and is 0 while the voice is idle. Only the bench scenarios can show the actual waveform shape. These cover how many ticks each position lasts for a given rate, which positions each duty code makes high, the exact envelope staircase with its end values, and the deferred effect of a rate change.

// File: rtl/pulse_tone_pkg.sv
package pulse_tone_pkg;
    localparam int DATA_W = 16;
    localparam int RATE_W = 11;
    localparam int VOL_W  = 4;
    localparam int TIME_W = 3;
    localparam int POS_W  = 3;

    localparam logic [RATE_W-1:0] RATE_TOP = {RATE_W{1'b1}};
    localparam logic [VOL_W-1:0]  VOL_TOP  = {VOL_W{1'b1}};
    localparam logic [VOL_W-1:0]  VOL_ONE  = {{(VOL_W-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {
        DUTY_EIGHTH  = 2'd0,
        DUTY_QUARTER = 2'd1,
        DUTY_HALF    = 2'd2,
        DUTY_WIDE    = 2'd3
    } duty_e;

    typedef struct packed {
        logic [VOL_W-1:0]  start_vol;
        logic              rising;
        logic [TIME_W-1:0] step_time;
        duty_e             duty;
        logic [5:0]        spare;
    } voice_ctrl_t;

    function automatic logic duty_level(duty_e code, logic [POS_W-1:0] pos);
        case (code)
            DUTY_EIGHTH:  return pos == 3'd0;
            DUTY_QUARTER: return pos < 3'd2;
            DUTY_HALF:    return pos < 3'd4;
            default:      return pos < 3'd6;
        endcase
    endfunction
endpackage

// File: rtl/pulse_tone_regs.sv
module pulse_tone_regs
    import pulse_tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output voice_ctrl_t       ctrl_q,
    output logic [RATE_W-1:0] rate_q,
    output logic [RATE_W-1:0] load_rate,
    output logic              restart,
    output logic              running
);
    logic unused_bits;
    assign unused_bits = ^{wr_data[14:RATE_W], ctrl_q.spare};

    assign restart   = wr_en && wr_sel && wr_data[DATA_W-1];
    assign load_rate = wr_data[RATE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            rate_q  <= '0;
            running <= 1'b0;
        end else begin
            if (wr_en && !wr_sel) ctrl_q <= voice_ctrl_t'(wr_data);
            if (wr_en && wr_sel)  rate_q <= load_rate;
            if (restart)          running <= 1'b1;
        end
    end

    // R1: the voice becomes active only through a restart write
    a_r1_start_on_restart: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(restart));
endmodule

// File: rtl/pulse_tone_period.sv
module pulse_tone_period
    import pulse_tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic              restart,
    input  logic              period_tick,
    input  logic [RATE_W-1:0] load_rate,
    input  logic [RATE_W-1:0] rate_q,
    output logic [POS_W-1:0]  pos
);
    logic [RATE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            pos <= '0;
        end else if (restart) begin
            cnt <= load_rate;
            pos <= '0;
        end else if (running && period_tick) begin
            if (cnt == RATE_TOP) begin
                cnt <= rate_q;
                pos <= pos + 3'd1;
            end else begin
                cnt <= cnt + {{(RATE_W-1){1'b0}}, 1'b1};
            end
        end
    end

    // R3: the duty position moves only on a period tick
    a_r3_pos_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (!period_tick && !restart) |=> $stable(pos));
    // R8: restart returns the pattern to position 0
    a_r8_restart_pos: assert property (@(posedge clk) disable iff (rst)
        restart |=> pos == '0);
endmodule

// File: rtl/pulse_tone_envelope.sv
module pulse_tone_envelope
    import pulse_tone_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic             restart,
    input  logic             env_tick,
    input  voice_ctrl_t      ctrl_q,
    output logic [VOL_W-1:0] vol
);
    logic              rising_l;
    logic [TIME_W-1:0] time_l;
    logic [TIME_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            vol      <= '0;
            rising_l <= 1'b0;
            time_l   <= '0;
            wait_cnt <= '0;
        end else if (restart) begin
            vol      <= ctrl_q.start_vol;
            rising_l <= ctrl_q.rising;
            time_l   <= ctrl_q.step_time;
            wait_cnt <= ctrl_q.step_time;
        end else if (running && env_tick && time_l != '0) begin
            if (wait_cnt <= 3'd1) begin
                wait_cnt <= time_l;
                if (rising_l && vol != VOL_TOP)   vol <= vol + VOL_ONE;
                if (!rising_l && vol != '0)       vol <= vol - VOL_ONE;
            end else begin
                wait_cnt <= wait_cnt - 3'd1;
            end
        end
    end

    // R5: a falling envelope never gains volume
    a_r5_no_rise: assert property (@(posedge clk) disable iff (rst)
        (!restart && !rising_l) |=> vol <= $past(vol));
    // R6: a rising envelope never loses volume
    a_r6_no_fall: assert property (@(posedge clk) disable iff (rst)
        (!restart && rising_l) |=> vol >= $past(vol));
    // R5: the volume moves by at most one unit per cycle
    a_r5_single_unit: assert property (@(posedge clk) disable iff (rst)
        !restart |=> (vol == $past(vol) || vol == $past(vol) + VOL_ONE
                      || vol == $past(vol) - VOL_ONE));
    // R7: zero step time freezes the volume
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (!restart && time_l == '0) |=> $stable(vol));
endmodule

// File: rtl/pulse_tone_voice.sv
module pulse_tone_voice
    import pulse_tone_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              period_tick,
    input  logic              env_tick,
    output logic [VOL_W-1:0]  sample
);
    voice_ctrl_t       ctrl_q;
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] load_rate;
    logic              restart;
    logic              running;
    logic [POS_W-1:0]  pos;
    logic [VOL_W-1:0]  vol;

    pulse_tone_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_q(ctrl_q), .rate_q(rate_q), .load_rate(load_rate),
        .restart(restart), .running(running)
    );

    pulse_tone_period u_period (
        .clk(clk), .rst(rst), .running(running), .restart(restart),
        .period_tick(period_tick), .load_rate(load_rate), .rate_q(rate_q),
        .pos(pos)
    );

    pulse_tone_envelope u_env (
        .clk(clk), .rst(rst), .running(running), .restart(restart),
        .env_tick(env_tick), .ctrl_q(ctrl_q), .vol(vol)
    );

    always_comb begin
        if (running && duty_level(ctrl_q.duty, pos)) sample = vol;
        else                                          sample = '0;
    end

    // R4: the output is either silence or the current volume
    a_r4_level: assert property (@(posedge clk) disable iff (rst)
        sample == '0 || sample == vol);
    // R1: an idle voice is silent
    a_r1_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !running |-> sample == '0);
endmodule

// File: tb/tb_pulse_tone_voice.sv
module tb_pulse_tone_voice;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        period_tick = 1'b0;
    logic        env_tick = 1'b0;
    logic [3:0]  sample;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_tone_voice dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .period_tick(period_tick), .env_tick(env_tick), .sample(sample)
    );

    // vector: duty[24:23] vol[22:19] rate[18:8] high-position mask[7:0]
    localparam logic [24:0] VEC [6] = '{
        {2'd0, 4'd15, 11'd2047, 8'b0000_0001},
        {2'd1, 4'd7,  11'd2046, 8'b0000_0011},
        {2'd2, 4'd12, 11'd2044, 8'b0000_1111},
        {2'd3, 4'd5,  11'd2047, 8'b0011_1111},
        {2'd2, 4'd1,  11'd2045, 8'b0000_1111},
        {2'd3, 4'd9,  11'd2043, 8'b0011_1111}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_word(input logic sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ctrl_word(input logic [3:0] v, input logic up, input logic [2:0] t,
                             input logic [1:0] d);
        write_word(1'b0, {v, up, t, d, 6'b0});
    endtask

    task automatic ptick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); period_tick = 1'b1;
            @(negedge clk); period_tick = 1'b0;
        end
    endtask

    task automatic etick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); env_tick = 1'b1;
            @(negedge clk); env_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset output", sample, 4'd0);

        // R1: control and plain frequency writes alone keep the voice silent
        ctrl_word(4'd15, 1'b0, 3'd0, 2'd3);
        write_word(1'b1, 16'h07FF);
        ptick(3); etick(2);
        check("R1 idle after writes", sample, 4'd0);

        // R2/R3/R4: table walk over duty codes and rates
        foreach (VEC[k]) begin
            logic [1:0]  d;
            logic [3:0]  v;
            logic [10:0] r;
            logic [7:0]  m;
            int          len;
            {d, v, r, m} = VEC[k];
            len = 2048 - int'(r);
            ctrl_word(v, 1'b0, 3'd0, d);
            write_word(1'b1, {1'b1, 4'b0, r});
            for (int s = 0; s < 8; s++) begin
                check("R4 duty position level", sample, m[s] ? v : 4'd0);
                if (len > 1) begin
                    ptick(len - 1);
                    check("R3 position held until last tick", sample, m[s] ? v : 4'd0);
                    ptick(1);
                end else begin
                    ptick(1);
                end
            end
            check("R3 wrap to position 0", sample, v);
        end

        // R5: falling staircase, step time 2, start 3
        ctrl_word(4'd3, 1'b0, 3'd2, 2'd2);
        write_word(1'b1, 16'h8000);
        check("R5 start volume", sample, 4'd3);
        etick(1); check("R5 before step", sample, 4'd3);
        etick(1); check("R5 first step", sample, 4'd2);
        etick(2); check("R5 second step", sample, 4'd1);
        etick(2); check("R5 reaches 0", sample, 4'd0);
        etick(4); check("R5 holds at 0", sample, 4'd0);

        // R8: restart mid-envelope restores start volume and position 0
        ctrl_word(4'd3, 1'b0, 3'd2, 2'd0);
        write_word(1'b1, 16'h87FF);
        check("R8 restart volume", sample, 4'd3);
        ptick(1);
        check("R8 restart position advanced", sample, 4'd0);
        write_word(1'b1, 16'h87FF);
        check("R8 restart position 0", sample, 4'd3);

        // R6: rising staircase, step time 1, start 13
        ctrl_word(4'd13, 1'b1, 3'd1, 2'd2);
        write_word(1'b1, 16'h8000);
        etick(1); check("R6 rise 1", sample, 4'd14);
        etick(1); check("R6 rise 2", sample, 4'd15);
        etick(3); check("R6 holds at 15", sample, 4'd15);

        // R7: zero step time keeps start volume
        ctrl_word(4'd9, 1'b0, 3'd0, 2'd2);
        write_word(1'b1, 16'h8000);
        etick(5); check("R7 volume frozen", sample, 4'd9);

        // R9: rate change without restart applies at next rollover
        ctrl_word(4'd6, 1'b0, 3'd0, 2'd1);
        write_word(1'b1, {1'b1, 4'b0, 11'd2046});
        write_word(1'b1, {1'b0, 4'b0, 11'd2044});
        check("R9 no restart on plain write", sample, 4'd6);
        ptick(1); check("R9 old length position 0", sample, 4'd6);
        ptick(1); check("R9 rollover to position 1", sample, 4'd6);
        ptick(3); check("R9 new length still position 1", sample, 4'd6);
        ptick(1); check("R9 position 2 low", sample, 4'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule